// File: doc/BRIEF.md
# Circular Push Receive Queue

This block receives 64-bit entries from a producer and stores each one into a circular buffer held in local memory, through a single write port. A consumer watches the queue through a status word that carries both pointers and the empty and full flags, reads entries straight from memory, and frees them one at a time by writing to an increment register. A level-sensitive interrupt follows the live queue state. Software picks whether it asserts whenever data is waiting or only once the buffer is full.

The buffer length is programmed as entries minus one, with up to 2^PTR_W entries. The base address is a separate register. It must be aligned to the power of two at or above the buffer size, and to at least one cache line, so that the slot offset can be merged into it with an OR. The read pointer names the last slot consumed, so the next entry to read sits one slot past it. The write pointer names the last slot filled. Bad traffic raises a sticky receive error flag: a push into a full queue, or an increment on an empty one.

Top module: `push_rx_queue`

## Requirements
- R1: After reset the queue is disabled. Both pointers are 0, the empty flag is 1, the full flag is 0, the interrupt is low, the error flag is 0 and no memory write is issued.
- R2: Registers are selected by regAddr: 0 control/status, 1 base, 2 increment, 3 receive status. The control/status word has enable at bit 0 and the interrupt action at bit 1, where 1 means full and 0 means not-empty. After those come the length minus one at [2 +: PTR_W], the read pointer at [2+PTR_W +: PTR_W], the write pointer at [2+2*PTR_W +: PTR_W], empty at bit 2+3*PTR_W and full at bit 3+3*PTR_W. Writing this word loads enable, action and length, and clears both pointers and the full flag, which discards all contents.
- R3: An accepted entry produces memWe in the same cycle, with memData equal to inData and memAddr equal to base OR (slot*8). The slot is the one just past the write pointer. The write pointer moves to that slot at the next edge.
- R4: Both pointers step from the value length-minus-one to 0.
- R5: A write of any data to the increment register, while the queue is not empty, advances the read pointer by one slot.
- R6: The empty flag is 1 exactly when the pointers are equal and full is 0. Full becomes 1 when an accepted entry brings the write pointer onto the read pointer. An increment clears it.
- R7: The irq output equals enable AND (full when action is 1, not-empty when action is 0). It follows the state in every cycle and has no clear.
- R8: While disabled, inValid is ignored: no memory write occurs, the pointers do not move and no error is raised.
- R9: An entry that arrives while the queue is full is dropped, with no memory write and no pointer movement, and it sets the error flag.
- R10: An increment write while the queue is empty leaves the read pointer unchanged and sets the error flag.
- R11: The error flag reads at bit 0 of the receive status register. It stays set until a write to that register with bit 0 equal to 1. A new error in the same cycle as that write keeps the flag set.
- R12: The base register reads back the value last written to it.
- R13: An entry presented in the same cycle as a control/status write is dropped without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming entry present |
| inData | input | ENTRY_W | Incoming entry |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data for regAddr |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | REG_W | Buffer memory byte address |
| memData | output | ENTRY_W | Buffer memory write data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with PTR_W set to 3, so the largest queue holds 8 entries. At that size a full-capacity run, several wraps of both pointers and repeated fills all fit in a short run. Programming the length to zero gives a single-entry queue, where full and not-empty coincide and every pointer step is also a wrap. A pseudo-random phase reprograms lengths and actions while pushes and increments overlap, and this reaches the cases where both act in one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [1:0] ADDR_CSR   = 2'd0;
  localparam logic [1:0] ADDR_BASE  = 2'd1;
  localparam logic [1:0] ADDR_INC   = 2'd2;
  localparam logic [1:0] ADDR_RSTAT = 2'd3;

  typedef struct packed {
    logic csrLoad;
    logic baseLoad;
    logic pushStep;
    logic popStep;
  } qStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic       clrBit,
  input  logic       enable,
  input  logic       action,
  input  logic       isEmpty,
  input  logic       isFull,
  output qStrobe_t   strb,
  output logic       rcvErr,
  output logic       irq
);
  logic incReq, pushReq, errSet, errClr;

  always_comb begin
    strb.csrLoad  = regWr && (regAddr == ADDR_CSR);
    strb.baseLoad = regWr && (regAddr == ADDR_BASE);
    incReq        = regWr && (regAddr == ADDR_INC);
    pushReq       = inValid && enable && !strb.csrLoad;
    strb.pushStep = pushReq && !isFull;
    strb.popStep  = incReq && !isEmpty;
    errSet        = (pushReq && isFull) || (incReq && isEmpty);
    errClr        = regWr && (regAddr == ADDR_RSTAT) && clrBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       rcvErr <= 1'b0;
    else if (errSet) rcvErr <= 1'b1;
    else if (errClr) rcvErr <= 1'b0;
  end

  assign irq = enable && (action ? isFull : !isEmpty);

  // R9: overflow raises the error flag
  a_r9_overflow_err: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && enable && isFull && !(regWr && regAddr == ADDR_CSR)) |=> rcvErr);
  // R10: increment on empty raises the error flag
  a_r10_underflow_err: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_INC && isEmpty) |=> rcvErr);
  // R11: flag stays set without a status write
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rcvErr && !(regWr && regAddr == ADDR_RSTAT)) |=> rcvErr);
  // R8: no step while disabled
  a_r8_no_push_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strb.pushStep);
endmodule

// File: rtl/rxq_dpath.sv
module rxq_dpath
  import rxq_pkg::*;
#(
  parameter int PTR_W   = 4,
  parameter int REG_W   = 32,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  qStrobe_t           strb,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [ENTRY_W-1:0] inData,
  input  logic               rcvErr,
  output logic               enable,
  output logic               action,
  output logic               isEmpty,
  output logic               isFull,
  output logic               memWe,
  output logic [REG_W-1:0]   memAddr,
  output logic [ENTRY_W-1:0] memData,
  output logic [REG_W-1:0]   regRdata
);
  localparam int SLOT_SH = $clog2(ENTRY_W / 8);
  localparam int RD_LSB  = 2 + PTR_W;
  localparam int WR_LSB  = 2 + 2 * PTR_W;
  localparam int EMP_BIT = 2 + 3 * PTR_W;
  localparam int FUL_BIT = 3 + 3 * PTR_W;

  logic [PTR_W-1:0] lenM1, rdPtr, wrPtr, rdNext, wrNext;
  logic [REG_W-1:0] base, csrWord;
  logic             full;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p,
                                               input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  assign rdNext = stepPtr(rdPtr, lenM1);
  assign wrNext = stepPtr(wrPtr, lenM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      action <= 1'b0;
      lenM1  <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
      full   <= 1'b0;
    end else if (strb.csrLoad) begin
      enable <= regWdata[0];
      action <= regWdata[1];
      lenM1  <= regWdata[2 +: PTR_W];
      rdPtr  <= '0;
      wrPtr  <= '0;
      full   <= 1'b0;
    end else begin
      if (strb.pushStep) wrPtr <= wrNext;
      if (strb.popStep)  rdPtr <= rdNext;
      if (strb.pushStep && !strb.popStep)      full <= (wrNext == rdPtr);
      else if (strb.popStep && !strb.pushStep) full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              base <= '0;
    else if (strb.baseLoad) base <= regWdata;
  end

  assign isFull  = full;
  assign isEmpty = (rdPtr == wrPtr) && !full;
  assign memWe   = strb.pushStep;
  assign memData = inData;
  assign memAddr = base | (REG_W'(wrNext) << SLOT_SH);

  always_comb begin
    csrWord                   = '0;
    csrWord[0]                = enable;
    csrWord[1]                = action;
    csrWord[2 +: PTR_W]       = lenM1;
    csrWord[RD_LSB +: PTR_W]  = rdPtr;
    csrWord[WR_LSB +: PTR_W]  = wrPtr;
    csrWord[EMP_BIT]          = isEmpty;
    csrWord[FUL_BIT]          = full;
    unique case (regAddr)
      ADDR_CSR:   regRdata = csrWord;
      ADDR_BASE:  regRdata = base;
      ADDR_RSTAT: regRdata = REG_W'(rcvErr);
      default:    regRdata = '0;
    endcase
  end

  // R4: pointers stay within the programmed length
  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr <= lenM1) && (wrPtr <= lenM1));
  // R6: full only with coinciding pointers
  a_r6_full_ptrs: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (rdPtr == wrPtr));
  // R6: full is only ever entered through an accepted entry
  a_r6_full_from_push: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> $past(strb.pushStep));
  // R2: control write discards contents
  a_r2_csr_discard: assert property (@(posedge clk) disable iff (!rstN)
    strb.csrLoad |=> (rdPtr == '0 && wrPtr == '0 && !full));
endmodule

// File: rtl/push_rx_queue.sv
module push_rx_queue
  import rxq_pkg::*;
#(
  parameter int PTR_W   = 4,
  parameter int REG_W   = 32,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ENTRY_W-1:0] inData,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic               memWe,
  output logic [REG_W-1:0]   memAddr,
  output logic [ENTRY_W-1:0] memData,
  output logic               irq
);
  qStrobe_t strb;
  logic     enable, action, isEmpty, isFull, rcvErr;

  rxq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .regWr(regWr),
    .regAddr(regAddr), .clrBit(regWdata[0]), .enable(enable),
    .action(action), .isEmpty(isEmpty), .isFull(isFull),
    .strb(strb), .rcvErr(rcvErr), .irq(irq)
  );

  rxq_dpath #(.PTR_W(PTR_W), .REG_W(REG_W), .ENTRY_W(ENTRY_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .inData(inData), .rcvErr(rcvErr),
    .enable(enable), .action(action), .isEmpty(isEmpty), .isFull(isFull),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .regRdata(regRdata)
  );

  // R3: a memory write never happens into a full queue
  a_r3_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !isFull);
endmodule

// File: tb/sim_push_rx_queue.sv
module sim_push_rx_queue;
  localparam int PW = 3;
  logic        clk = 0, rstN = 0;
  logic        inValid = 0, regWr = 0;
  logic [63:0] inData = '0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata, memAddr;
  logic [63:0] memData;
  logic        memWe, irq;
  int errors = 0, checks = 0;
  int mEn = 0, mAct = 0, mLen = 0, mRd = 0, mWr = 0, mFull = 0, mErr = 0;
  logic [31:0] mBase = '0;
  logic [31:0] lfsr = 32'h1d2c3b4a;

  always #2 clk = ~clk;

  push_rx_queue #(.PTR_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == mLen) ? 0 : p + 1;
  endfunction

  function automatic int mEmpty();
    return (mRd == mWr && mFull == 0) ? 1 : 0;
  endfunction

  function automatic logic [31:0] csrExp();
    return 32'(mEn) | 32'(mAct) << 1 | 32'(mLen) << 2 | 32'(mRd) << (2 + PW)
         | 32'(mWr) << (2 + 2 * PW) | 32'(mEmpty()) << (2 + 3 * PW)
         | 32'(mFull) << (3 + 3 * PW);
  endfunction

  // one cycle: drive, compare every output, advance the model
  task automatic step(input logic v, input logic [63:0] d, input logic w,
                      input logic [1:0] a, input logic [31:0] wd);
    logic expWe, pushOk, incOk, errSet;
    logic [31:0] expRd;
    @(negedge clk);
    inValid = v; inData = d; regWr = w; regAddr = a; regWdata = wd;
    #1;
    pushOk = v && mEn != 0 && mFull == 0 && !(w && a == 2'd0);
    incOk  = w && a == 2'd2 && mEmpty() == 0;
    expWe  = pushOk;
    check("R3 memWe", 64'(memWe), 64'(expWe));
    if (expWe) begin
      check("R3 memAddr", 64'(memAddr), 64'(mBase | 32'(nxt(mWr)) << 3));
      check("R3 memData", memData, d);
    end
    check("R7 irq", 64'(irq),
          64'(mEn != 0 && (mAct != 0 ? mFull != 0 : mEmpty() == 0)));
    if (!w) begin
      case (a)
        2'd0: expRd = csrExp();
        2'd1: expRd = mBase;
        2'd3: expRd = 32'(mErr);
        default: expRd = '0;
      endcase
      check(a == 2'd1 ? "R12 readback" : a == 2'd3 ? "R11 status" : "R2 csr",
            64'(regRdata), 64'(expRd));
    end
    // model update
    errSet = (v && mEn != 0 && mFull != 0 && !(w && a == 2'd0)) ||
             (w && a == 2'd2 && mEmpty() != 0);
    if (w && a == 2'd0) begin
      mEn = int'(wd[0]); mAct = int'(wd[1]); mLen = int'(wd[2 +: PW]);
      mRd = 0; mWr = 0; mFull = 0;
    end else begin
      if (pushOk && !incOk) mFull = (nxt(mWr) == mRd) ? 1 : 0;
      else if (incOk && !pushOk) mFull = 0;
      if (pushOk) mWr = nxt(mWr);
      if (incOk)  mRd = nxt(mRd);
    end
    if (w && a == 2'd1) mBase = wd;
    if (errSet) mErr = 1;
    else if (w && a == 2'd3 && wd[0]) mErr = 0;
    @(posedge clk);
  endtask

  task automatic rd(input logic [1:0] a); step(0, '0, 0, a, '0); endtask
  task automatic push(input logic [63:0] d); step(1, d, 0, 2'd0, '0); endtask
  task automatic inc(); step(0, '0, 1, 2'd2, 32'hdead_beef); endtask
  task automatic csr(input int en, input int act, input int len);
    step(0, '0, 1, 2'd0, 32'(en) | 32'(act) << 1 | 32'(len) << 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state: empty bit at 2+3*PW = 11
    #1;
    check("R1 csr after reset", 64'(regRdata), 64'(32'h800));
    check("R1 irq after reset", 64'(irq), 0);
    check("R1 memWe after reset", 64'(memWe), 0);
    rd(2'd3);
    // R12 base
    step(0, '0, 1, 2'd1, 32'h1000_0000);
    rd(2'd1);
    // R8 pushes while disabled
    push(64'h11); push(64'h12); rd(2'd0); rd(2'd3);
    check("R8 no error while disabled", 64'(regRdata), 0);
    // 4-entry queue, not-empty interrupt
    csr(1, 0, 3); rd(2'd0);
    push(64'ha1);
    #1 check("R7 irq after first push", 64'(irq), 1);
    push(64'ha2); push(64'ha3); push(64'ha4);
    // R4/R6: slots 1,2,3,0 -> wr wrapped to 0, full
    @(negedge clk); regWr = 0; inValid = 0; regAddr = 2'd0; #1;
    check("R6 full after four pushes", 64'(regRdata), 64'(32'h100D));
    // R9 overflow
    push(64'hbad); rd(2'd3);
    check("R9 overflow sets error", 64'(regRdata), 1);
    step(0, '0, 1, 2'd3, 32'h1); rd(2'd3);
    // R5 consume
    inc(); inc(); inc(); inc(); rd(2'd0);
    check("R5 read pointer wrapped to 0", 64'(regRdata[7:5]), 0);
    // R10 underflow
    inc(); rd(2'd3);
    check("R10 underflow sets error", 64'(regRdata), 1);
    // R11 set wins over clear: clear write while pushing into full queue
    push(1); push(2); push(3); push(4);
    step(1, 64'h5, 1, 2'd3, 32'h1); rd(2'd3);
    check("R11 set wins over clear", 64'(regRdata), 1);
    step(0, '0, 1, 2'd3, 32'h1); rd(2'd3);
    // R13 push during control write
    step(1, 64'h77, 1, 2'd0, 32'h1D); rd(2'd0);
    check("R13 push dropped on csr write", 64'(regRdata[10:8]), 0);
    // single-entry queue, full action
    csr(1, 1, 0);
    #1 check("R7 irq low when empty full-mode", 64'(irq), 0);
    push(64'hc1);
    #1 check("R7 irq on full", 64'(irq), 1);
    step(1, 64'hc2, 1, 2'd2, 0); rd(2'd0);
    push(64'hc3); inc(); rd(2'd0);
    // full 8-entry queue, overlapping push and increment
    csr(1, 0, 7);
    for (int i = 0; i < 20; i++) step(1, 64'(i) * 64'h0101, (i % 3) != 0, 2'd2, 0);
    rd(2'd0);
    // R2 discard by writing zero
    step(0, '0, 1, 2'd0, 0); rd(2'd0);
    check("R2 disabled empty after zero write", 64'(regRdata), 64'(32'h800));
    // pseudo-random phase
    csr(1, 0, 5);
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[9:5] == 0)
        step(lfsr[0], {lfsr, lfsr}, 1, 2'd0, {28'(0), lfsr[12:10], 1'b1} | 32'(lfsr[13]) << 1);
      else if (lfsr[9:5] == 1) step(lfsr[0], {lfsr, ~lfsr}, 1, 2'd3, 32'h1);
      else if (lfsr[9:5] == 2) step(lfsr[0], 64'(lfsr), 1, 2'd1, lfsr & 32'hffff_ff80);
      else step(lfsr[0], {~lfsr, lfsr}, lfsr[2:1] == 2'b11, lfsr[2:1] == 2'b11 ? 2'd2 : lfsr[4:3], 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule